// File: doc/BRIEF.md
# Decode-Stage Hazard Stall and Flush Controller

This block watches the instruction sitting in the decode stage of a five-stage in-order pipeline that resolves branches in decode. It compares the decode instruction's source register numbers with the destinations of the two instructions ahead of it, one in the execute stage and one in the memory stage. When an operand cannot be supplied in time, it freezes the program counter and the fetch/decode register. It also forces the control bits entering execute to zero, so a bubble moves down the pipe.

There are three kinds of hazard. A load in execute stalls any consumer for one cycle. A branch compares its operands in decode, so it stalls for one cycle behind an ALU producer. Behind a load it stalls twice: once while the load is in execute and once while it is in memory. A branch that resolves taken without a stall squashes the instruction fetched after it. Fetch always proceeds down the fall-through path, so a branch that is not taken costs nothing. The controller is purely combinational from its data inputs. The clock and reset are used only by the embedded property checks.

Top module: `hazard_ctl`

## Requirements
- R1: A load-use stall occurs when `ex_memread` is 1, `ex_dst` is nonzero and `ex_dst` equals `id_rs` or `id_rt`, for any decode class except no-source.
- R2: During a stall `bubble`=1, `pc_write`=0 and `ifid_write`=0. With no stall, `bubble`=0, `pc_write`=1 and `ifid_write`=1.
- R3: A decode instruction of class branch (`id_class`=2'b01) stalls when `ex_regwrite`=1, `ex_dst` is nonzero and `ex_dst` matches `id_rs` or `id_rt`. This holds for an ALU producer as well as a load.
- R4: A branch stalls when the memory-stage instruction is a load (`mem_memread`=1 and `mem_regwrite`=1) whose nonzero `mem_dst` matches a branch operand. A memory-stage ALU result (`mem_memread`=0) causes no stall.
- R5: A load immediately before a branch gives exactly two consecutive stall cycles as the load moves from execute to memory. The cycle after that has no stall.
- R6: A destination equal to register 0 never causes a stall.
- R7: A decode instruction of class no-source (`id_class`=2'b10) never stalls. Classes 2'b00 and 2'b11 are regular instructions that read both sources.
- R8: `if_flush`=1 exactly when the class is branch, `br_taken`=1 and there is no stall. A branch that is not taken leaves `if_flush`=0 and `pc_write`=1.
- R9: While a stall is active, `if_flush` stays 0 even when `br_taken`=1.
- R10: A regular (non-branch) instruction whose source matches an execute-stage ALU destination (`ex_memread`=0) does not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used for the property checks |
| rst_n | input | 1 | Active-low reset, disables the property checks |
| id_rs | input | REG_W | First source register of the decode instruction |
| id_rt | input | REG_W | Second source register of the decode instruction |
| id_class | input | 2 | Decode class: 00 regular, 01 branch, 10 no-source, 11 regular |
| br_taken | input | 1 | Branch compare outcome computed in decode |
| ex_dst | input | REG_W | Destination register of the execute-stage instruction |
| ex_regwrite | input | 1 | Execute-stage instruction writes a register |
| ex_memread | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | REG_W | Destination register of the memory-stage instruction |
| mem_regwrite | input | 1 | Memory-stage instruction writes a register |
| mem_memread | input | 1 | Memory-stage instruction is a load |
| pc_write | output | 1 | Allow the program counter to advance |
| ifid_write | output | 1 | Allow the fetch/decode register to load |
| bubble | output | 1 | Force zero control into the execute-stage register |
| if_flush | output | 1 | Squash the fetch/decode register on a taken branch |

## Verification
Random input patterns over a register space of only four numbers make source and destination collisions frequent. These patterns separate the load-use match on each source, the effect of the register-write flag, and the register-zero exclusion. Directed cases take a branch behind an ALU producer, behind a load one stage away and behind a load two stages away. Together these show which producer and distance combinations stall and which are forwarded. A three-step load-then-branch sequence confirms that the stall lasts exactly two cycles and that the flush appears only after the stall ends. A regular consumer behind an ALU producer shows that only branches stall for non-load producers.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    CLS_REG   = 2'b00,
    CLS_BR    = 2'b01,
    CLS_NOSRC = 2'b10,
    CLS_REG2  = 2'b11
  } dec_class_e;

  localparam int unsigned NSRC = 2;

  function automatic logic reads_sources(input dec_class_e c);
    return c != CLS_NOSRC;
  endfunction
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
  parameter int unsigned W    = 5,
  parameter int unsigned NSRC = 2
) (
  input  logic [NSRC-1:0][W-1:0] srcs,
  input  logic [W-1:0]           dst,
  input  logic                   en,
  output logic                   hit
);
  logic [NSRC-1:0] eq;
  logic            dst_live;

  assign dst_live = en && (dst != '0);

  for (genvar i = 0; i < NSRC; i++) begin : g_cmp
    assign eq[i] = (srcs[i] == dst);
  end

  assign hit = dst_live && (|eq);
endmodule

// File: rtl/hz_loaduse.sv
module hz_loaduse
  import hz_pkg::*;
#(
  parameter int unsigned W = 5
) (
  input  logic [NSRC-1:0][W-1:0] srcs,
  input  dec_class_e             cls,
  input  logic [W-1:0]           ex_dst,
  input  logic                   ex_memread,
  output logic                   stall
);
  logic hit;

  hz_src_match #(.W(W), .NSRC(NSRC)) u_m (
    .srcs(srcs), .dst(ex_dst), .en(ex_memread), .hit(hit)
  );

  assign stall = hit && reads_sources(cls);
endmodule

// File: rtl/hz_branch.sv
module hz_branch
  import hz_pkg::*;
#(
  parameter int unsigned W = 5
) (
  input  logic [NSRC-1:0][W-1:0] srcs,
  input  dec_class_e             cls,
  input  logic [W-1:0]           ex_dst,
  input  logic                   ex_regwrite,
  input  logic [W-1:0]           mem_dst,
  input  logic                   mem_regwrite,
  input  logic                   mem_memread,
  output logic                   stall
);
  logic is_br;
  logic hit_ex;
  logic hit_mem;

  assign is_br = (cls == CLS_BR);

  // Any producer one stage ahead is too late for a decode compare.
  hz_src_match #(.W(W), .NSRC(NSRC)) u_ex (
    .srcs(srcs), .dst(ex_dst), .en(ex_regwrite), .hit(hit_ex)
  );

  // Two stages ahead, only a load is still unresolved.
  hz_src_match #(.W(W), .NSRC(NSRC)) u_mem (
    .srcs(srcs), .dst(mem_dst), .en(mem_regwrite && mem_memread), .hit(hit_mem)
  );

  assign stall = is_br && (hit_ex || hit_mem);
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
  import hz_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic [1:0]       id_class,
  input  logic             br_taken,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_regwrite,
  input  logic             ex_memread,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_regwrite,
  input  logic             mem_memread,
  output logic             pc_write,
  output logic             ifid_write,
  output logic             bubble,
  output logic             if_flush
);
  dec_class_e               cls;
  logic [NSRC-1:0][REG_W-1:0] srcs;
  logic                     lu_stall;
  logic                     br_stall;
  logic                     stall;

  assign cls     = dec_class_e'(id_class);
  assign srcs[0] = id_rs;
  assign srcs[1] = id_rt;

  hz_loaduse #(.W(REG_W)) u_lu (
    .srcs(srcs), .cls(cls), .ex_dst(ex_dst), .ex_memread(ex_memread),
    .stall(lu_stall)
  );

  hz_branch #(.W(REG_W)) u_br (
    .srcs(srcs), .cls(cls), .ex_dst(ex_dst), .ex_regwrite(ex_regwrite),
    .mem_dst(mem_dst), .mem_regwrite(mem_regwrite), .mem_memread(mem_memread),
    .stall(br_stall)
  );

  assign stall      = lu_stall || br_stall;
  assign bubble     = stall;
  assign pc_write   = !stall;
  assign ifid_write = !stall;
  assign if_flush   = (cls == CLS_BR) && br_taken && !stall;

  // R1: a load producing a nonzero source of a reading instruction freezes fetch
  assert_loaduse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_memread && ex_dst != '0 && (ex_dst == id_rs || ex_dst == id_rt)
     && id_class != 2'b10) |-> (!pc_write && bubble));

  // R6: no destination other than zero means the zero register cannot stall
  assert_zero_reg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_dst == '0 && mem_dst == '0) |-> (pc_write && ifid_write && !bubble));

  // R7: an instruction without sources always advances
  assert_nosrc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (id_class == 2'b10) |-> (pc_write && !bubble && !if_flush));

  // R9: a flush never coincides with a bubble
  assert_flush_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    if_flush |-> (ifid_write && !bubble));

  // R4: a forwarded ALU result two stages ahead is never waited on
  assert_mem_alu_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_regwrite && !ex_memread && !mem_memread) |-> pc_write);
endmodule

// File: tb/sim_hazard_ctl.sv
module sim_hazard_ctl;
  localparam int W = 5;

  logic clk = 0;
  logic rst_n = 0;
  logic [W-1:0] id_rs = 0, id_rt = 0, ex_dst = 0, mem_dst = 0;
  logic [1:0] id_class = 0;
  logic br_taken = 0, ex_regwrite = 0, ex_memread = 0, mem_regwrite = 0, mem_memread = 0;
  logic pc_write, ifid_write, bubble, if_flush;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hazard_ctl #(.REG_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .id_rs(id_rs), .id_rt(id_rt), .id_class(id_class),
    .br_taken(br_taken), .ex_dst(ex_dst), .ex_regwrite(ex_regwrite),
    .ex_memread(ex_memread), .mem_dst(mem_dst), .mem_regwrite(mem_regwrite),
    .mem_memread(mem_memread), .pc_write(pc_write), .ifid_write(ifid_write),
    .bubble(bubble), .if_flush(if_flush)
  );

  // Behavioural reference: expected {pc_write, ifid_write, bubble, if_flush}
  function automatic logic [3:0] model();
    bit reads, br, uses_ex, uses_mem, st;
    reads = (id_class != 2'b10);
    br = (id_class == 2'b01);
    uses_ex = (ex_dst != 0) && (ex_dst == id_rs || ex_dst == id_rt);
    uses_mem = (mem_dst != 0) && (mem_dst == id_rs || mem_dst == id_rt);
    st = 0;
    if (reads && ex_memread && uses_ex) st = 1;
    if (br && ex_regwrite && uses_ex) st = 1;
    if (br && mem_regwrite && mem_memread && uses_mem) st = 1;
    return {!st, !st, st, br && br_taken && !st};
  endfunction

  task automatic check(input string req);
    logic [3:0] exp, act;
    exp = model();
    act = {pc_write, ifid_write, bubble, if_flush};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic expect_bits(input string req, input logic [3:0] exp);
    checks++;
    if ({pc_write, ifid_write, bubble, if_flush} !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", req, {pc_write, ifid_write, bubble, if_flush}, exp);
    end
  endtask

  task automatic apply(input logic [1:0] c, input logic [W-1:0] rs, rt,
                       input logic tk, input logic [W-1:0] ed, input logic ew, er,
                       input logic [W-1:0] md, input logic mw, mr);
    @(posedge clk); #5;
    id_class = c; id_rs = rs; id_rt = rt; br_taken = tk;
    ex_dst = ed; ex_regwrite = ew; ex_memread = er;
    mem_dst = md; mem_regwrite = mw; mem_memread = mr;
    #5;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #15;
    expect_bits("reset R2", 4'b1100);
    @(posedge clk); #3; rst_n = 1;

    // R1 load-use on rs, then on rt, R2 outputs during stall
    apply(2'b00, 5'd3, 5'd4, 0, 5'd3, 1, 1, 5'd0, 0, 0); expect_bits("R1 rs R2", 4'b0010);
    apply(2'b11, 5'd7, 5'd4, 0, 5'd4, 1, 1, 5'd0, 0, 0); expect_bits("R1 rt", 4'b0010);
    // R10 regular consumer of ALU result: forwarded
    apply(2'b00, 5'd3, 5'd4, 0, 5'd3, 1, 0, 5'd3, 1, 1); expect_bits("R10", 4'b1100);
    // R3 branch behind ALU producer
    apply(2'b01, 5'd5, 5'd6, 1, 5'd6, 1, 0, 5'd0, 0, 0); expect_bits("R3 R9", 4'b0010);
    // R4 branch behind memory-stage ALU: no stall, taken -> flush R8
    apply(2'b01, 5'd5, 5'd6, 1, 5'd0, 0, 0, 5'd5, 1, 0); expect_bits("R4 alu R8", 4'b1101);
    // R4 branch behind memory-stage load
    apply(2'b01, 5'd5, 5'd6, 0, 5'd0, 0, 0, 5'd5, 1, 1); expect_bits("R4 load", 4'b0010);
    // R8 not-taken branch
    apply(2'b01, 5'd5, 5'd6, 0, 5'd9, 1, 1, 5'd9, 1, 1); expect_bits("R8 not taken", 4'b1100);
    // R6 register zero
    apply(2'b01, 5'd0, 5'd0, 1, 5'd0, 1, 1, 5'd0, 1, 1); expect_bits("R6", 4'b1101);
    // R7 no-source class
    apply(2'b10, 5'd3, 5'd3, 1, 5'd3, 1, 1, 5'd3, 1, 1); expect_bits("R7", 4'b1100);

    // R5 load then taken branch: two stalls, then flush
    apply(2'b01, 5'd8, 5'd2, 1, 5'd8, 1, 1, 5'd0, 0, 0); expect_bits("R5 stall1 R9", 4'b0010);
    apply(2'b01, 5'd8, 5'd2, 1, 5'd0, 0, 0, 5'd8, 1, 1); expect_bits("R5 stall2", 4'b0010);
    apply(2'b01, 5'd8, 5'd2, 1, 5'd0, 0, 0, 5'd0, 0, 0); expect_bits("R5 release R8", 4'b1101);

    // Random patterns in a small register space, compared every clock
    for (int i = 0; i < 3000; i++) begin
      apply(2'($urandom), 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)), 1'($urandom),
            5'($urandom_range(0, 3)), 1'($urandom), 1'($urandom),
            5'($urandom_range(0, 3)), 1'($urandom), 1'($urandom));
      check("random R1 R3 R4 R6 R8");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule